// File: doc/BRIEF.md
# External Bus Cycle Sequencer

This block runs one beat at a time on an external asynchronous device bus: a read or a write, on its own or as part of a burst. Address decoding and byte-lane steering happen elsewhere. The block receives a decoded device index together with a held beat request. Each device has its own configuration slice, which sets:

- the meaning of the shared handshake line (wait or acknowledge);
- whether burst reads and burst writes are allowed;
- write protection;
- whether the external data buffers are enabled;
- three timing counts.

Each beat passes through an address setup phase, a strobe phase and a release (hold) phase. During the beat the block drives the read/write level, the read strobe, the write strobe, the data-buffer enable and the buffer direction. It pulses `beat_done` in the last cycle of the beat, and the requester drops or changes its request after seeing that pulse.

The handshake line `wa_async` is asynchronous to `clk`. Two flops resynchronise it before the strobe logic uses it. In wait mode a high level extends the strobe. In acknowledge mode the strobe ends only after a high level has been seen.

Top module: `ext_bus_seq`

## Requirements
- R1: While reset is asserted, and afterwards with no request, the outputs sit at `bus_rwn`=1, `bus_oe_n`=1, `bus_we_n`=1, `buf_oe_n`=1, `buf_dir_n`=0, `beat_done`=0 and `prot_err`=0.
- R2: An accepted beat takes one request cycle, then setup+1 cycles, then at least width+1 strobe cycles, then hold+1 release cycles. `beat_done` is high only in the final release cycle. The counts come from the device's 4-bit slice of `cfg_setup`, `cfg_width` and `cfg_hold` (device d uses bits 4d+3..4d).
- R3: In the strobe phase a read drives `bus_oe_n` low and a write drives `bus_we_n` low; the two are never low together. `bus_rwn` is 0 for the whole of a write beat and 1 otherwise.
- R4: With `cfg_ack_mode[d]`=0 (wait mode), the strobe phase does not end while the synchronised handshake is high.
- R5: With `cfg_ack_mode[d]`=1 (acknowledge mode), the strobe phase ends only once the synchronised handshake is high.
- R6: A change on `wa_async` reaches the strobe-end decision through exactly two flops. A level driven before clock edge k is first acted on in the cycle after edge k+1.
- R7: A beat with `req_burst`=1 skips the setup phase if the device's burst enable for that direction (`cfg_brd_en` for reads, `cfg_bwr_en` for writes) is set. If that enable is clear, the beat runs the full setup phase like a single beat.
- R8: A write request to a device with `cfg_wr_prot[d]`=1 pulses `beat_done` in its request cycle and drives no strobe. It sets `prot_err`, which stays high until reset. Reads from that device run normally.
- R9: `buf_dir_n` is always the inverse of `bus_rwn`.
- R10: `buf_oe_n` is low for every cycle of an accepted beat (setup, strobe and release) if `cfg_buf_en[d]`=1, and is high otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req | input | 1 | Beat request, held until `beat_done` |
| req_dev | input | IDXW (2) | Decoded device index |
| req_wr | input | 1 | 1 = write beat, 0 = read beat |
| req_burst | input | 1 | Beat continues a burst |
| cfg_ack_mode | input | NDEV (4) | Per device: 1 = acknowledge mode, 0 = wait mode |
| cfg_brd_en | input | NDEV (4) | Per device burst read enable |
| cfg_bwr_en | input | NDEV (4) | Per device burst write enable |
| cfg_wr_prot | input | NDEV (4) | Per device write protect |
| cfg_buf_en | input | NDEV (4) | Per device data-buffer enable |
| cfg_setup | input | NDEV*CNTW (16) | Address-to-strobe counts |
| cfg_width | input | NDEV*CNTW (16) | Minimum strobe counts |
| cfg_hold | input | NDEV*CNTW (16) | Release counts |
| wa_async | input | 1 | Asynchronous wait/acknowledge line |
| bus_rwn | output | 1 | Read (1) / write (0) level |
| bus_oe_n | output | 1 | Read strobe, active low |
| bus_we_n | output | 1 | Write strobe, active low |
| buf_oe_n | output | 1 | Data-buffer enable, active low |
| buf_dir_n | output | 1 | Data-buffer direction |
| beat_done | output | 1 | Beat completion pulse |
| prot_err | output | 1 | Sticky write-protect violation flag |

## Verification
A corrupted phase counter changes the length of a beat: `beat_done` arrives early or late, and the strobe lasts a different number of cycles. A per-cycle comparison catches this in the first wrong cycle, and the bench's request-to-done count catches it again when the beat ends. If the synchronizer has a missing or extra stage, or the handshake polarity is wrong, the strobe end moves by at least one cycle. The bench makes that shift visible by holding the handshake for a known number of cycles. A wrong latched direction or device index shows up within a cycle on `bus_rwn`, on `buf_oe_n`, or as a strobe on the wrong pin.

// File: rtl/ext_bus_seq.sv
module ext_bus_seq #(
  parameter int NDEV = 4,
  parameter int CNTW = 4,
  localparam int IDXW = (NDEV > 1) ? $clog2(NDEV) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 req,
  input  logic [IDXW-1:0]      req_dev,
  input  logic                 req_wr,
  input  logic                 req_burst,
  input  logic [NDEV-1:0]      cfg_ack_mode,
  input  logic [NDEV-1:0]      cfg_brd_en,
  input  logic [NDEV-1:0]      cfg_bwr_en,
  input  logic [NDEV-1:0]      cfg_wr_prot,
  input  logic [NDEV-1:0]      cfg_buf_en,
  input  logic [NDEV*CNTW-1:0] cfg_setup,
  input  logic [NDEV*CNTW-1:0] cfg_width,
  input  logic [NDEV*CNTW-1:0] cfg_hold,
  input  logic                 wa_async,
  output logic                 bus_rwn,
  output logic                 bus_oe_n,
  output logic                 bus_we_n,
  output logic                 buf_oe_n,
  output logic                 buf_dir_n,
  output logic                 beat_done,
  output logic                 prot_err
);

  typedef enum logic [1:0] {S_IDLE, S_SETUP, S_STRB, S_HOLD} st_t;

  st_t             st;
  logic [CNTW-1:0] cnt;
  logic [IDXW-1:0] dev;
  logic            wr;
  logic            wa_s1, wa_s2;

  wire             prot     = req && req_wr && cfg_wr_prot[req_dev];
  wire             burst_ok = req_burst && (req_wr ? cfg_bwr_en[req_dev] : cfg_brd_en[req_dev]);
  wire             hs_ok    = cfg_ack_mode[dev] ? wa_s2 : !wa_s2;
  wire             active   = (st != S_IDLE);

  assign bus_rwn   = active ? !wr : 1'b1;
  assign bus_oe_n  = !(st == S_STRB && !wr);
  assign bus_we_n  = !(st == S_STRB && wr);
  assign buf_oe_n  = !(active && cfg_buf_en[dev]);
  assign buf_dir_n = !bus_rwn;
  assign beat_done = (st == S_HOLD && cnt == '0) || (st == S_IDLE && prot);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wa_s1 <= 1'b0;
      wa_s2 <= 1'b0;
    end else begin
      wa_s1 <= wa_async;
      wa_s2 <= wa_s1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      cnt      <= '0;
      dev      <= '0;
      wr       <= 1'b0;
      prot_err <= 1'b0;
    end else begin
      case (st)
        S_IDLE: begin
          if (prot) prot_err <= 1'b1;
          else if (req) begin
            dev <= req_dev;
            wr  <= req_wr;
            if (burst_ok) begin
              st  <= S_STRB;
              cnt <= cfg_width[req_dev*CNTW +: CNTW];
            end else begin
              st  <= S_SETUP;
              cnt <= cfg_setup[req_dev*CNTW +: CNTW];
            end
          end
        end
        S_SETUP: begin
          if (cnt == '0) begin
            st  <= S_STRB;
            cnt <= cfg_width[dev*CNTW +: CNTW];
          end else cnt <= cnt - 1'b1;
        end
        S_STRB: begin
          if (cnt != '0) cnt <= cnt - 1'b1;
          else if (hs_ok) begin
            st  <= S_HOLD;
            cnt <= cfg_hold[dev*CNTW +: CNTW];
          end
        end
        default: begin
          if (cnt == '0) st <= S_IDLE;
          else cnt <= cnt - 1'b1;
        end
      endcase
    end
  end

  // R3
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(!bus_oe_n && !bus_we_n));

  // R3
  rwn_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_oe_n || !bus_we_n) |=> (!bus_oe_n || !bus_we_n) |-> $stable(bus_rwn));

  // R8
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    prot_err |=> prot_err);

  // R4
  wait_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (($rose(bus_oe_n) || $rose(bus_we_n)) && !cfg_ack_mode[dev]) |-> !$past(wa_s2));

  // R5
  ack_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (($rose(bus_oe_n) || $rose(bus_we_n)) && cfg_ack_mode[dev]) |-> $past(wa_s2));

  // R10
  buf_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !buf_oe_n |-> (cfg_buf_en[dev] && (bus_rwn != buf_dir_n)));

endmodule

// File: tb/ext_bus_seq_tb.sv
module ext_bus_seq_tb_top;
  localparam int NDEV = 4;
  localparam int CNTW = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req = 1'b0, req_wr = 1'b0, req_burst = 1'b0, wa = 1'b0;
  logic [1:0] req_dev = '0;
  logic [NDEV-1:0] c_ack, c_bre, c_bwe, c_wp, c_be;
  logic [NDEV*CNTW-1:0] c_setup, c_width, c_hold;
  logic rwn, oe_n, we_n, boe_n, dir_n, done, err;

  int nchk = 0, nerr = 0, cyc = 0;
  int st_a[NDEV] = '{2, 1, 1, 0};
  int wd_a[NDEV] = '{3, 0, 1, 2};
  int hd_a[NDEV] = '{1, 0, 0, 2};

  ext_bus_seq #(.NDEV(NDEV), .CNTW(CNTW)) dut_i (
    .clk(clk), .rst_n(rst_n), .req(req), .req_dev(req_dev), .req_wr(req_wr),
    .req_burst(req_burst), .cfg_ack_mode(c_ack), .cfg_brd_en(c_bre),
    .cfg_bwr_en(c_bwe), .cfg_wr_prot(c_wp), .cfg_buf_en(c_be),
    .cfg_setup(c_setup), .cfg_width(c_width), .cfg_hold(c_hold),
    .wa_async(wa), .bus_rwn(rwn), .bus_oe_n(oe_n), .bus_we_n(we_n),
    .buf_oe_n(boe_n), .buf_dir_n(dir_n), .beat_done(done), .prot_err(err));

  always #2.5 clk = ~clk;

  initial begin
    c_ack = 4'b1010; c_bre = 4'b1001; c_bwe = 4'b1010;
    c_wp  = 4'b0100; c_be  = 4'b1101;
    for (int i = 0; i < NDEV; i++) begin
      c_setup[i*CNTW +: CNTW] = CNTW'(st_a[i]);
      c_width[i*CNTW +: CNTW] = CNTW'(wd_a[i]);
      c_hold[i*CNTW +: CNTW]  = CNTW'(hd_a[i]);
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // behavioural reference: phase number, remaining count, handshake history queue
  int ph = 0, left = 0, mdev = 0, mwr = 0;
  bit merr = 0;
  bit hist[$] = '{0, 0};

  always @(posedge clk) begin
    if (!rst_n) begin
      ph = 0; left = 0; mdev = 0; mwr = 0; merr = 0; hist = '{0, 0};
    end else begin
      bit seen;
      seen = hist[0];
      if (ph == 0) begin
        if (req && req_wr && c_wp[req_dev]) merr = 1;
        else if (req) begin
          mdev = req_dev; mwr = req_wr;
          if (req_burst && (req_wr ? c_bwe[req_dev] : c_bre[req_dev])) begin
            ph = 2; left = wd_a[req_dev];
          end else begin
            ph = 1; left = st_a[req_dev];
          end
        end
      end else if (ph == 1) begin
        if (left == 0) begin ph = 2; left = wd_a[mdev]; end else left--;
      end else if (ph == 2) begin
        if (left > 0) left--;
        else if (c_ack[mdev] ? seen : !seen) begin ph = 3; left = hd_a[mdev]; end
      end else begin
        if (left == 0) ph = 0; else left--;
      end
      void'(hist.pop_front());
      hist.push_back(wa);
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      bit e_rwn, e_oe, e_we, e_boe, e_done;
      e_rwn  = (ph == 0) ? 1'b1 : !mwr[0];
      e_oe   = !(ph == 2 && mwr == 0);
      e_we   = !(ph == 2 && mwr == 1);
      e_boe  = !(ph != 0 && c_be[mdev]);
      e_done = (ph == 3 && left == 0) || (ph == 0 && req && req_wr && c_wp[req_dev]);
      if (rwn !== e_rwn)           check(0, "R3 rwn", rwn, e_rwn);
      else if (oe_n !== e_oe)      check(0, "R3 oe_n", oe_n, e_oe);
      else if (we_n !== e_we)      check(0, "R3 we_n", we_n, e_we);
      else if (boe_n !== e_boe)    check(0, "R10 buf_oe_n", boe_n, e_boe);
      else if (dir_n !== !e_rwn)   check(0, "R9 buf_dir_n", dir_n, !e_rwn);
      else if (done !== e_done)    check(0, "R2 beat_done", done, e_done);
      else if (err !== merr)       check(0, "R8 prot_err", err, merr);
      else                         check(1, "cycle", 0, 0);
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      nerr++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  end

  task automatic beat(input int d, input bit w, input bit b, input int hc,
                      input int exp_len, input string tag);
    int n = 0;
    bit strobed = 0;
    @(posedge clk); #1;
    req = 1; req_dev = 2'(d); req_wr = w; req_burst = b;
    wa = c_ack[d] ? (hc == 0) : (hc > 0);
    forever begin
      @(negedge clk);
      n++;
      if (!oe_n || !we_n) strobed = 1;
      if (done) break;
      @(posedge clk); #1;
      if (n == hc) wa = c_ack[d];
    end
    check(n == exp_len, tag, n, exp_len);
    if (w && c_wp[d]) check(!strobed, "R8 no strobe", strobed, 0);
    @(posedge clk); #1;
    req = 0; req_burst = 0; wa = 0;
    repeat (3) @(posedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1 outputs during reset
    check({rwn, oe_n, we_n, boe_n, dir_n, done, err} == 7'b1111000, "R1 reset",
          {rwn, oe_n, we_n, boe_n, dir_n, done, err}, 7'b1111000);
    #1 rst_n = 1;
    repeat (2) @(negedge clk);
    check({rwn, oe_n, we_n, boe_n, dir_n, done, err} == 7'b1111000, "R1 idle",
          {rwn, oe_n, we_n, boe_n, dir_n, done, err}, 7'b1111000);

    beat(0, 0, 0, 0, 10, "R2 single read");
    beat(0, 1, 0, 0, 10, "R2 single write");
    beat(0, 0, 0, 8, 13, "R4 wait stretch");
    beat(0, 0, 0, 6, 11, "R6 two flop wait");
    beat(1, 1, 0, 5, 9,  "R5 ack wait");
    beat(1, 0, 0, 0, 5,  "R5 ack present");
    beat(1, 0, 1, 0, 5,  "R7 burst read disabled");
    beat(0, 0, 1, 0, 7,  "R7 burst read skip");
    beat(0, 1, 1, 0, 10, "R7 burst write disabled");
    beat(3, 1, 1, 0, 7,  "R7 burst write skip");
    beat(3, 0, 0, 0, 8,  "R2 ack read");
    check(err == 0, "R8 flag clear", err, 0);
    beat(2, 1, 0, 0, 1,  "R8 protected write");
    check(err == 1, "R8 flag set", err, 1);
    beat(2, 0, 0, 0, 6,  "R8 read allowed");
    check(err == 1, "R8 flag sticky", err, 1);

    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule